// File: doc/BRIEF.md
# Transmit 8b/10b Encoder with Per-Byte Disparity Override

This block sits on the transmit side of a serial link and turns each accepted byte into a 10-bit DC-balanced code group. A flag that travels with the byte selects between the data alphabet and the control alphabet. The block keeps the running disparity of the line in a two-state machine, `RD_NEG` and `RD_POS`. It picks the code group variant that keeps the line balanced.

A caller may override the disparity choice one byte at a time. When the override flag is set, a second flag selects which variant is emitted: the one normally used from a negative running disparity, or the one normally used from a positive running disparity. The current state is ignored for that byte. The state then advances from the group actually sent. Together the override and the running disparity let a link layer set up a known line state, for example for an idle pattern that alternates disparity.

If a control group is requested for a byte that is not one of the twelve legal control characters, the block flags an error. It then sends the data group for that byte. All outputs are registered one cycle after the accepted input.

The state machine has two states, `RD_NEG` and `RD_POS`, and reset enters `RD_NEG`. With no valid input, every state holds. An accepted byte makes the next state the ending disparity of the emitted group. That ending disparity is worked out from the effective starting disparity, which is the override choice when forcing and the current state otherwise. So the transition is `RD_NEG`→`RD_POS` or `RD_POS`→`RD_NEG` when the group ends on the other sign, and a self-loop when it ends on the same sign.

Top module: `enc8b10b_tx`

## Requirements
- R1: While and after reset, and before any byte is accepted, `rd_o` is 0 (negative), `vld_o` is 0 and `kerr_o` is 0.
- R2: With `ctrl_i` low, the byte `{H,G,F,E,D,C,B,A}` = `byte_i[7:0]` is encoded as data group Dx.y, where x = `byte_i[4:0]` and y = `byte_i[7:5]`. The group is `code_o[9:0]` = `{a,b,c,d,e,i,f,g,h,j}`, with `a` at bit 9 sent first. Example: D21.5 (0xB5) gives 1010101010.
- R3: With no override, the group is the variant for the current running disparity (`rd_o` 1 = positive). After each group, `rd_o` is 1 if the group has six ones, 0 if it has four, and equal to the starting disparity if it has five. Example: D3.0 from negative gives 1100011011 and `rd_o` becomes 1.
- R4: With `ctrl_i` high and a legal byte, the control group is emitted. The legal bytes are K28.0–K28.7 (`byte_i[4:0]`=28), 0xF7, 0xFB, 0xFD and 0xFE. Examples: K28.5 (0xBC) gives 0011111010 from negative and 1100000101 from positive; K23.7 from negative gives 1110101000.
- R5: The 3b/4b alternate code for y=7 is used for x in {17,18,20} when the disparity after the 6-bit sub-block is negative, and for x in {11,13,14} when it is positive. Examples: D17.7 from negative gives 1000110111; D11.7 from positive gives 1101001000.
- R6: With `frc_i`=1 and `frc_neg_i`=1, the negative-disparity variant (the one for a negative starting disparity) is emitted whatever the state. Example: D0.0 from state positive gives 1001110100.
- R7: With `frc_i`=1 and `frc_neg_i`=0, the positive-disparity variant is emitted whatever the state. Example: D0.0 from state negative gives 0110001011.
- R8: After a forced group, the running disparity follows the R3 rule, with the forced variant's starting disparity taken as the starting disparity.
- R9: With `ctrl_i` high and a byte outside the R4 list, `kerr_o` is 1 for that group and the data group for the byte is emitted. For every other accepted byte, `kerr_o` is 0.
- R10: Outputs appear exactly one cycle after `vld_i` is sampled high, with `vld_o` high for that cycle. When `vld_i` is low, `vld_o` is 0 and `code_o` and `rd_o` keep their values whatever the other inputs do.
- R11: The flags apply only to the byte they arrive with. A byte sent without the override right after a forced byte is encoded from the disparity the forced byte left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Byte and flags are valid this cycle |
| byte_i | input | 8 | Byte to encode, bit 0 = A |
| ctrl_i | input | 1 | 1 = control group, 0 = data group |
| frc_i | input | 1 | Override the running disparity for this byte |
| frc_neg_i | input | 1 | With override: 1 = negative variant, 0 = positive variant |
| code_o | output | 10 | Code group, bit 9 = a (sent first) |
| rd_o | output | 1 | Running disparity after the last group, 1 = positive |
| kerr_o | output | 1 | Illegal control byte requested |
| vld_o | output | 1 | `code_o` carries a new group this cycle |

## Verification
The encoder has no tunable parameters: all widths are fixed by the code and sit in the package, so the bench elaborates the block at its only configuration. Both disparity states are reached with directed bytes. The override then drives each sub-block from the state it would not naturally be in, which exercises the D.x.7 alternate, the complement rules for both sub-blocks, and the forced-then-natural sequence. A long stream of random data bytes, legal control bytes and illegal control bytes, with random overrides, is checked against a reference model built from the positive-disparity column of the code tables.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;
    localparam int BYTE_W  = 8;
    localparam int LOW_W   = 5;
    localparam int HIGH_W  = BYTE_W - LOW_W;
    localparam int SIX_W   = LOW_W + 1;
    localparam int FOUR_W  = HIGH_W + 1;
    localparam int CODE_W  = SIX_W + FOUR_W;

    // running disparity state
    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    function automatic rd_e rd_flip(input rd_e v);
        return (v == RD_NEG) ? RD_POS : RD_NEG;
    endfunction
endpackage

// File: rtl/enc_sub6.sv
module enc_sub6
    import enc8b10b_pkg::*;
(
    input  logic [LOW_W-1:0] x_i,
    input  logic             k28_i,
    input  rd_e              rd_i,
    output logic [SIX_W-1:0] six_o,
    output rd_e              rd_o
);
    logic [SIX_W-1:0] base;
    logic             unbal;
    logic             flip;

    // negative-start column, bits {a,b,c,d,e,i}
    always_comb begin
        base = 6'b000000;
        unique case (x_i)
            5'd0:  base = 6'b100111;
            5'd1:  base = 6'b011101;
            5'd2:  base = 6'b101101;
            5'd3:  base = 6'b110001;
            5'd4:  base = 6'b110101;
            5'd5:  base = 6'b101001;
            5'd6:  base = 6'b011001;
            5'd7:  base = 6'b111000;
            5'd8:  base = 6'b111001;
            5'd9:  base = 6'b100101;
            5'd10: base = 6'b010101;
            5'd11: base = 6'b110100;
            5'd12: base = 6'b001101;
            5'd13: base = 6'b101100;
            5'd14: base = 6'b011100;
            5'd15: base = 6'b010111;
            5'd16: base = 6'b011011;
            5'd17: base = 6'b100011;
            5'd18: base = 6'b010011;
            5'd19: base = 6'b110010;
            5'd20: base = 6'b001011;
            5'd21: base = 6'b101010;
            5'd22: base = 6'b011010;
            5'd23: base = 6'b111010;
            5'd24: base = 6'b110011;
            5'd25: base = 6'b100110;
            5'd26: base = 6'b010110;
            5'd27: base = 6'b110110;
            5'd28: base = 6'b001110;
            5'd29: base = 6'b101110;
            5'd30: base = 6'b011110;
            5'd31: base = 6'b101011;
            default: base = 6'b000000;
        endcase
        if (k28_i) begin
            base = 6'b001111;
        end
    end

    always_comb begin
        unbal = ($countones(base) != 3);
        // D.7 is balanced but still has two forms
        flip  = (rd_i == RD_POS) && (unbal || (x_i == 5'd7 && !k28_i));
        six_o = flip ? ~base : base;
        rd_o  = unbal ? rd_flip(rd_i) : rd_i;
    end
endmodule

// File: rtl/enc_sub4.sv
module enc_sub4
    import enc8b10b_pkg::*;
(
    input  logic [HIGH_W-1:0] y_i,
    input  logic [LOW_W-1:0]  x_i,
    input  logic              k_i,
    input  rd_e               rd_i,
    output logic [FOUR_W-1:0] four_o,
    output rd_e               rd_o
);
    logic [FOUR_W-1:0] base;
    logic              use_alt;
    logic              unbal;
    logic              flip;

    // alternate y=7 form avoids five equal bits across the sub-block seam
    always_comb begin
        use_alt = 1'b0;
        if (y_i == 3'd7) begin
            if (k_i) begin
                use_alt = 1'b1;
            end else if (rd_i == RD_NEG) begin
                use_alt = (x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20);
            end else begin
                use_alt = (x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14);
            end
        end
    end

    // negative-start column, bits {f,g,h,j}
    always_comb begin
        base = 4'b0000;
        unique case (y_i)
            3'd0: base = 4'b1011;
            3'd1: base = k_i ? 4'b0110 : 4'b1001;
            3'd2: base = k_i ? 4'b1010 : 4'b0101;
            3'd3: base = 4'b1100;
            3'd4: base = 4'b1101;
            3'd5: base = k_i ? 4'b0101 : 4'b1010;
            3'd6: base = k_i ? 4'b1001 : 4'b0110;
            3'd7: base = use_alt ? 4'b0111 : 4'b1110;
            default: base = 4'b0000;
        endcase
    end

    always_comb begin
        unbal  = ($countones(base) != 2);
        flip   = (rd_i == RD_POS) && (unbal || k_i || y_i == 3'd3);
        four_o = flip ? ~base : base;
        rd_o   = unbal ? rd_flip(rd_i) : rd_i;
    end
endmodule

// File: rtl/enc_kcheck.sv
module enc_kcheck
    import enc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              legal_o,
    output logic              is28_o
);
    logic [LOW_W-1:0]  x;
    logic [HIGH_W-1:0] y;

    always_comb begin
        x       = byte_i[LOW_W-1:0];
        y       = byte_i[BYTE_W-1:LOW_W];
        is28_o  = (x == 5'd28);
        legal_o = is28_o ||
                  ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                   (x == 5'd29) || (x == 5'd30)));
    end
endmodule

// File: rtl/enc8b10b_tx.sv
module enc8b10b_tx
    import enc8b10b_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vld_i,
    input  logic [7:0]  byte_i,
    input  logic        ctrl_i,
    input  logic        frc_i,
    input  logic        frc_neg_i,
    output logic [9:0]  code_o,
    output logic        rd_o,
    output logic        kerr_o,
    output logic        vld_o
);
    rd_e               rd_q, rd_d;
    rd_e               rd_start;
    rd_e               rd_mid;
    rd_e               rd_end;
    logic              k_legal;
    logic              k_is28;
    logic              k_use;
    logic [SIX_W-1:0]  six;
    logic [FOUR_W-1:0] four;
    logic [CODE_W-1:0] code_q;
    logic              kerr_q;
    logic              vld_q;

    enc_kcheck u_kchk (
        .byte_i  (byte_i),
        .legal_o (k_legal),
        .is28_o  (k_is28)
    );

    always_comb begin
        k_use = ctrl_i && k_legal;
        if (frc_i) begin
            rd_start = frc_neg_i ? RD_NEG : RD_POS;
        end else begin
            rd_start = rd_q;
        end
    end

    enc_sub6 u_six (
        .x_i   (byte_i[LOW_W-1:0]),
        .k28_i (ctrl_i && k_is28),
        .rd_i  (rd_start),
        .six_o (six),
        .rd_o  (rd_mid)
    );

    enc_sub4 u_four (
        .y_i    (byte_i[BYTE_W-1:LOW_W]),
        .x_i    (byte_i[LOW_W-1:0]),
        .k_i    (k_use),
        .rd_i   (rd_mid),
        .four_o (four),
        .rd_o   (rd_end)
    );

    // next-state logic of the disparity machine
    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_NEG:  if (vld_i) rd_d = rd_end;
            RD_POS:  if (vld_i) rd_d = rd_end;
            default: rd_d = RD_NEG;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= RD_NEG;
        end else begin
            rd_q <= rd_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            kerr_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= vld_i;
            if (vld_i) begin
                code_q <= {six, four};
                kerr_q <= ctrl_i && !k_legal;
            end
        end
    end

    assign code_o = code_q;
    assign rd_o   = rd_q;
    assign kerr_o = kerr_q;
    assign vld_o  = vld_q;

    // emitted groups carry four, five or six ones
    p_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ($countones(code_o) >= 4 && $countones(code_o) <= 6));

    // an unbalanced group sets the running disparity to its own sign
    p_rd_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $countones(code_o) != 5) |-> (rd_o == ($countones(code_o) == 6)));

    p_force_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && frc_i && frc_neg_i) |=> ($countones(code_o) >= 5));

    p_force_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && frc_i && !frc_neg_i) |=> ($countones(code_o) <= 5));

    p_bad_k_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && ctrl_i && !k_legal) |=> kerr_o);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> (!vld_o && $stable(rd_o) && $stable(code_o)));
endmodule

// File: tb/enc8b10b_tx_tb_top.sv
`timescale 1ns/1ps
module enc8b10b_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vld_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       ctrl_i = 1'b0;
    logic       frc_i = 1'b0;
    logic       frc_neg_i = 1'b0;
    logic [9:0] code_o;
    logic       rd_o;
    logic       kerr_o;
    logic       vld_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic tb_rd = 1'b0;

    logic [11:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    enc8b10b_tx dut_i (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .byte_i(byte_i),
        .ctrl_i(ctrl_i), .frc_i(frc_i), .frc_neg_i(frc_neg_i),
        .code_o(code_o), .rd_o(rd_o), .kerr_o(kerr_o), .vld_o(vld_o)
    );

    // positive-start column of the 6-bit table
    function automatic logic [5:0] pos6(input logic [4:0] x);
        logic [5:0] v;
        case (x)
            5'd0: v = 6'b011000;  5'd1: v = 6'b100010;  5'd2: v = 6'b010010;  5'd3: v = 6'b110001;
            5'd4: v = 6'b001010;  5'd5: v = 6'b101001;  5'd6: v = 6'b011001;  5'd7: v = 6'b000111;
            5'd8: v = 6'b000110;  5'd9: v = 6'b100101;  5'd10: v = 6'b010101; 5'd11: v = 6'b110100;
            5'd12: v = 6'b001101; 5'd13: v = 6'b101100; 5'd14: v = 6'b011100; 5'd15: v = 6'b101000;
            5'd16: v = 6'b100100; 5'd17: v = 6'b100011; 5'd18: v = 6'b010011; 5'd19: v = 6'b110010;
            5'd20: v = 6'b001011; 5'd21: v = 6'b101010; 5'd22: v = 6'b011010; 5'd23: v = 6'b000101;
            5'd24: v = 6'b001100; 5'd25: v = 6'b100110; 5'd26: v = 6'b010110; 5'd27: v = 6'b001001;
            5'd28: v = 6'b001110; 5'd29: v = 6'b010001; 5'd30: v = 6'b100001; default: v = 6'b010100;
        endcase
        return v;
    endfunction

    function automatic logic [3:0] pos4(input logic [2:0] y);
        logic [3:0] v;
        case (y)
            3'd0: v = 4'b0100; 3'd1: v = 4'b1001; 3'd2: v = 4'b0101; 3'd3: v = 4'b0011;
            3'd4: v = 4'b0010; 3'd5: v = 4'b1010; 3'd6: v = 4'b0110; default: v = 4'b0001;
        endcase
        return v;
    endfunction

    function automatic logic legal_k(input logic [7:0] b);
        return (b[4:0] == 5'd28) || (b == 8'hF7) || (b == 8'hFB) || (b == 8'hFD) || (b == 8'hFE);
    endfunction

    // reference encoder: start disparity s (1 = positive)
    function automatic logic [9:0] ref_enc(input logic [7:0] b, input logic k, input logic s);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] p6, c6;
        logic [3:0] p4, c4;
        logic       m;
        logic       alt;
        x = b[4:0];
        y = b[7:5];
        p6 = (k && x == 5'd28) ? 6'b110000 : pos6(x);
        if (s) c6 = p6;
        else if ($countones(p6) != 3 || x == 5'd7) c6 = ~p6;
        else c6 = p6;
        m = ($countones(c6) > 3) ? 1'b1 : ($countones(c6) < 3) ? 1'b0 : s;
        alt = (y == 3'd7) && (k || (!m && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                                   (m && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
        p4 = alt ? 4'b1000 : pos4(y);
        if (m) c4 = p4;
        else if (k || y == 3'd3 || $countones(p4) != 2) c4 = ~p4;
        else c4 = p4;
        return {c6, c4};
    endfunction

    // drive one byte; kat != 0 gives a fixed expected group
    task automatic send(input logic [7:0] b, input logic k, input logic f, input logic n,
                        input logic [9:0] kat, input string tag);
        logic       s;
        logic       kk;
        logic [9:0] e;
        int         ones;
        s  = f ? !n : tb_rd;
        kk = k && legal_k(b);
        e  = (kat != 10'd0) ? kat : ref_enc(b, kk, s);
        ones = $countones(e);
        tb_rd = (ones == 6) ? 1'b1 : (ones == 4) ? 1'b0 : s;
        q_exp.push_back({e, tb_rd, k && !legal_k(b)});
        q_tag.push_back(tag);
        vld_i = 1'b1; byte_i = b; ctrl_i = k; frc_i = f; frc_neg_i = n;
        @(negedge clk);
        vld_i = 1'b0;
    endtask

    task automatic check(input logic ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare each produced group
    always @(negedge clk) begin
        if (rst_n && vld_o) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R10 unexpected vld_o", {code_o, rd_o, kerr_o}, 12'h0);
            end else begin
                logic [11:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check({code_o, rd_o, kerr_o} == e, t, {code_o, rd_o, kerr_o}, e);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] hold_c;
        logic       hold_r;
        repeat (3) @(negedge clk);
        check(rd_o == 1'b0 && vld_o == 1'b0 && kerr_o == 1'b0, "R1 in reset",
              {code_o, rd_o, kerr_o}, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_o == 1'b0 && vld_o == 1'b0 && kerr_o == 1'b0, "R1 after reset",
              {code_o, rd_o, kerr_o}, 12'h0);

        send(8'hBC, 1, 0, 0, 10'b0011111010, "R4 K28.5 neg");
        send(8'hBC, 1, 0, 0, 10'b1100000101, "R4 K28.5 pos");
        send(8'hB5, 0, 0, 0, 10'b1010101010, "R2 D21.5");
        send(8'hF1, 0, 0, 0, 10'b1000110111, "R5 D17.7 neg");
        send(8'hEB, 0, 0, 0, 10'b1101001000, "R5 D11.7 pos");
        send(8'h03, 0, 0, 0, 10'b1100011011, "R3 D3.0 neg");
        send(8'h00, 0, 1, 1, 10'b1001110100, "R6 forced neg D0.0");
        send(8'h00, 0, 1, 0, 10'b0110001011, "R7 forced pos D0.0");
        send(8'hBC, 1, 1, 0, 10'b1100000101, "R8 forced pos K28.5");
        send(8'h00, 0, 0, 0, 10'b1001110100, "R11 natural after forced");
        send(8'h00, 1, 0, 0, 10'b1001110100, "R9 illegal control");
        send(8'hF7, 1, 0, 0, 10'b1110101000, "R4 K23.7 neg");
        send(8'hFC, 1, 0, 0, 10'b0011111000, "R4 K28.7 neg");
        @(negedge clk);

        hold_c = code_o;
        hold_r = rd_o;
        byte_i = 8'h5A; ctrl_i = 1'b1; frc_i = 1'b1; frc_neg_i = 1'b0;
        repeat (4) @(negedge clk);
        check(code_o == hold_c && rd_o == hold_r && !vld_o, "R10 idle hold",
              {code_o, rd_o, vld_o}, {hold_c, hold_r, 1'b0});

        for (int i = 0; i < 400; i++) begin
            logic [7:0] b;
            logic       k;
            int         sel;
            sel = $urandom_range(0, 9);
            b = 8'($urandom);
            k = 1'b0;
            if (sel < 2) begin
                k = 1'b1;
                b = {3'($urandom), 5'd28};
            end else if (sel == 2) begin
                k = 1'b1;
                case ($urandom_range(0, 3))
                    0: b = 8'hF7; 1: b = 8'hFB; 2: b = 8'hFD; default: b = 8'hFE;
                endcase
            end else if (sel == 3) begin
                k = 1'b1;
            end
            send(b, k, ($urandom_range(0, 3) == 0), 1'($urandom), 10'd0,
                 k ? "R9 random control" : "R3 random data");
            if ($urandom_range(0, 7) == 0) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(q_exp.size() == 0, "R10 all groups produced", 12'(q_exp.size()), 12'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule